// File: doc/BRIEF.md
# Sized Doorbell Write Generator

This block issues at most one sized memory write when a transfer finishes. A start strobe presents a target address, an attribute byte and a 32-bit payload. The attribute byte carries an enable flag and a two-bit size code that selects a byte, halfword or word access. The block checks that the address is naturally aligned to the selected size. It keeps only the low-order payload bits that fit that size, moves them onto the matching byte lanes, and forms the byte strobes.

Once a write is accepted, it is presented on a valid/ready request port and held unchanged until the fabric takes it. A completion pulse follows the handshake. When the enable flag is clear, no write is issued and the completion pulse comes on its own. An illegal size code or a misaligned address also suppresses the write; in that case the completion pulse comes together with an error pulse. A start that arrives while a write is still pending is ignored.

Top module: `db_writer`

## Requirements
- R1: With attribute bit 7 clear, no bus write is issued, and `done_o` pulses in the cycle after start with `err_o` low, whatever the size code or address.
- R2: With attribute bit 7 set, size code bits 1:0 select the access. Code 0 is 32-bit with strobe 4'b1111. Code 1 is 16-bit with strobe 4'b0011 shifted left by address bits 1:0. Code 2 is 8-bit with strobe 4'b0001 shifted left by address bits 1:0.
- R3: A write whose address is not naturally aligned is suppressed. Natural alignment means bit 0 clear for 16-bit and bits 1:0 clear for 32-bit. `done_o` and `err_o` both pulse in the cycle after start.
- R4: Size code 3 with bit 7 set is suppressed, and `done_o` and `err_o` both pulse in the cycle after start.
- R5: Bus data holds only the low 8, 16 or 32 payload bits, shifted left by 8 times address bits 1:0. All other lanes are zero, so upper payload bits have no effect.
- R6: Attribute bits 6:2 have no effect on any output.
- R7: `bus_valid_o` rises in the cycle after an accepted start. It stays high, with address, data and strobe stable, until a cycle in which `bus_ready_i` is high.
- R8: `done_o` pulses, with `err_o` low, in the cycle after the cycle in which `bus_valid_o` and `bus_ready_i` are both high. `bus_valid_o` is low in that cycle.
- R9: A start asserted while `bus_valid_o` is high is ignored.
- R10: After reset, `bus_valid_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| addr_i | input | 64 | Doorbell address |
| attr_i | input | 8 | Bit 7 enable, bits 1:0 size code |
| data_i | input | 32 | Doorbell payload |
| bus_valid_o | output | 1 | Write request valid |
| bus_ready_i | input | 1 | Fabric accepts the request |
| bus_addr_o | output | 64 | Write address |
| bus_data_o | output | 32 | Lane-aligned write data |
| bus_strb_o | output | 4 | Byte strobes |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Rejection pulse, coincident with done |

## Verification
Every result is due a fixed number of cycles after the edge that causes it. A bus request is due one cycle after an accepted start. A completion pulse, with or without error, is due one cycle after a skipped or rejected start. A completion pulse is also due one cycle after a completed handshake. The bench keeps a behavioural model that is advanced at each rising edge from the same inputs the design samples. All outputs are compared with that model at the falling edge of every cycle, so each of these latencies is checked exactly and never through a wait loop. Ready is held low for several cycles in some cases to check payload hold. Starts are driven during pending writes to confirm they are dropped.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_RSVD = 2'd3
  } db_size_e;

  localparam int unsigned EN_BIT = 7;
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8,
  parameter int unsigned OFF_W  = $clog2(LANES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LANES-1:0]  strb_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fault_o
);
  logic [LANES-1:0]  base_strb;
  logic              aligned;
  logic [DATA_W-1:0] byte_mask;

  always_comb begin
    base_strb = '0;
    aligned   = 1'b0;
    unique case (db_size_e'(size_i))
      SZ_WORD: begin base_strb = {LANES{1'b1}}; aligned = (off_i == '0); end
      SZ_HALF: begin base_strb = LANES'(2'b11);  aligned = ~off_i[0];     end
      SZ_BYTE: begin base_strb = LANES'(1'b1);   aligned = 1'b1;          end
      default: begin base_strb = '0;             aligned = 1'b0;          end
    endcase
  end

  // expand the unshifted strobe into a per-bit payload mask
  always_comb begin
    for (int i = 0; i < LANES; i++) byte_mask[i*8 +: 8] = {8{base_strb[i]}};
  end

  assign strb_o  = base_strb << off_i;
  assign data_o  = (data_i & byte_mask) << {off_i, 3'b000};
  assign fault_o = ~aligned;
endmodule

// File: rtl/db_port.sv
module db_port #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  strb_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  strb_o,
  output logic              done_o,
  output logic              err_o
);
  logic valid_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  strb_q;
  logic accept;

  assign accept = start_i & ~valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (valid_q) begin
        if (ready_i) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end else if (accept) begin
        if (!enable_i) begin
          done_q <= 1'b1;
        end else if (fault_i) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          valid_q <= 1'b1;
          addr_q  <= addr_i;
          data_q  <= data_i;
          strb_q  <= strb_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign strb_o  = strb_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o) && $stable(strb_o));

  p_done_after_hs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> done_o && !err_o && !valid_o);

  p_err_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !valid_o);

  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && start_i |=> !done_o);

  p_strb_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(strb_o) == 1 || $countones(strb_o) == 2 || strb_o == '1));
endmodule

// File: rtl/db_writer.sv
module db_writer
  import db_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        attr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic [LANES-1:0]  bus_strb_o,
  output logic              done_o,
  output logic              err_o
);
  logic [LANES-1:0]  dec_strb;
  logic [DATA_W-1:0] dec_data;
  logic              dec_fault;

  db_decode #(.DATA_W(DATA_W)) u_decode (
    .size_i (attr_i[1:0]),
    .off_i  (addr_i[OFF_W-1:0]),
    .data_i (data_i),
    .strb_o (dec_strb),
    .data_o (dec_data),
    .fault_o(dec_fault)
  );

  db_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .enable_i(attr_i[EN_BIT]),
    .fault_i (dec_fault),
    .addr_i  (addr_i),
    .data_i  (dec_data),
    .strb_i  (dec_strb),
    .valid_o (bus_valid_o),
    .ready_i (bus_ready_i),
    .addr_o  (bus_addr_o),
    .data_o  (bus_data_o),
    .strb_o  (bus_strb_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !bus_valid_o && !done_o && !err_o);
endmodule

// File: tb/sim_db_writer.sv
module sim_db_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] addr = '0;
  logic [7:0]  attr = '0;
  logic [31:0] data = '0;
  logic        ready = 1'b0;
  logic        b_valid, done, err;
  logic [63:0] b_addr;
  logic [31:0] b_data;
  logic [3:0]  b_strb;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R10";

  bit          m_valid, m_done, m_err;
  logic [63:0] m_addr;
  logic [31:0] m_data;
  logic [3:0]  m_strb;

  always #5 clk = ~clk;

  db_writer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .attr_i(attr),
    .data_i(data), .bus_valid_o(b_valid), .bus_ready_i(ready), .bus_addr_o(b_addr),
    .bus_data_o(b_data), .bus_strb_o(b_strb), .done_o(done), .err_o(err)
  );

  // behavioural reference, advanced on the same edge the design samples
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_valid) begin
        if (ready) begin m_valid = 0; m_done = 1; end
      end else if (start) begin
        int nbytes, off;
        longint unsigned keep;
        off = int'(addr[1:0]);
        nbytes = (attr[1:0] == 2'd0) ? 4 : (attr[1:0] == 2'd1) ? 2 : (attr[1:0] == 2'd2) ? 1 : 0;
        if (!attr[7]) m_done = 1;
        else if (nbytes == 0 || (off % nbytes) != 0) begin m_done = 1; m_err = 1; end
        else begin
          keep = (64'd1 << (8 * nbytes)) - 1;
          m_valid = 1;
          m_addr  = addr;
          m_data  = 32'((longint'(data) & keep) << (8 * off));
          m_strb  = 4'(((1 << nbytes) - 1) << off);
        end
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("valid", 64'(b_valid), 64'(m_valid));
    chk("done", 64'(done), 64'(m_done));
    chk("err", 64'(err), 64'(m_err));
    if (m_valid) begin
      chk("addr", b_addr, m_addr);
      chk("data", 64'(b_data), 64'(m_data));
      chk("strb", 64'(b_strb), 64'(m_strb));
    end
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic req(input logic [63:0] a, input logic [7:0] at, input logic [31:0] d, input int wait_n);
    @(negedge clk);
    start = 1; addr = a; attr = at; data = d; ready = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < wait_n; i++) @(negedge clk);
    ready = 1;
    @(negedge clk);
    ready = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R10";
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    req(64'h1000, 8'h00, 32'hDEADBEEF, 0);
    req(64'h1003, 8'h03, 32'h12345678, 0);
    tag = "R2";
    req(64'h2000, 8'h80, 32'hA1B2C3D4, 0);
    req(64'h2002, 8'h81, 32'h0000BEEF, 1);
    req(64'h2003, 8'h82, 32'h000000AB, 0);
    tag = "R5";
    req(64'h2001, 8'h82, 32'hFFFFFF5A, 0);
    req(64'h2000, 8'h81, 32'hCAFE1234, 0);
    req(64'h2002, 8'h81, 32'hCAFE1234, 0);
    tag = "R3";
    req(64'h3001, 8'h81, 32'h1111, 0);
    req(64'h3003, 8'h81, 32'h1111, 0);
    req(64'h3002, 8'h80, 32'h2222, 0);
    req(64'h3001, 8'h80, 32'h2222, 0);
    tag = "R4";
    req(64'h4000, 8'h83, 32'h3333, 0);
    tag = "R6";
    req(64'h5001, 8'hFE, 32'h00C0FFEE, 0);
    req(64'h5000, 8'hFC, 32'h87654321, 0);
    tag = "R7";
    req(64'h6000, 8'h80, 32'h55AA55AA, 5);
    tag = "R9";
    @(negedge clk);
    start = 1; addr = 64'h7000; attr = 8'h80; data = 32'h01020304;
    @(negedge clk);
    addr = 64'h7004; data = 32'h0BADF00D;
    repeat (3) @(negedge clk);
    start = 0; ready = 1;
    @(negedge clk);
    ready = 0;
    @(negedge clk);
    tag = "R8";
    @(negedge clk);
    start = 1; addr = 64'h8001; attr = 8'h82; data = 32'h77; ready = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    ready = 0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule